// File: doc/BRIEF.md
# Message-Based SPI Master Controller

This block is a register-driven SPI master that runs a whole message per command instead of one byte at a time. Software fills a transmit buffer through a memory window, writes a message word that gives a byte count and a message type, and then writes a command word that names the target device. The command starts the transfer. The block drives one active-low chip select per device, shifts 8-bit words MSB first on `sck`/`mosi`, and captures `miso` into a receive buffer. A tail count reports how many bytes the last message stored.

When a message ends, a command-done status bit is set. It drives `irq` when its mask bit is set. The serial clock rate comes from a three-bit code, and clock polarity and phase come from two mode bits, all held in one configuration register. A message longer than the buffer is sent as a chain of write messages, each issued once the previous one has completed.

Register window (`regAddr` bits [AW-1:AW-2] select the region; the low bits select the entry): region 0 holds the control registers, indexed by `regAddr[2:0]`. Index 0 is configuration, 1 is rate-code-only write, 2 is message, 3 is command, 4 is interrupt status, 5 is interrupt mask, 6 is receive tail and 7 is busy status. Region 1 is the transmit buffer and region 2 is the receive buffer, one byte per entry.

Top module: `spim_top`

## Requirements
- R1: After reset every `csN` bit is 1, `sck` and `mosi` are 0, `irq` is 0, and the configuration, interrupt status, receive tail and busy registers all read 0.
- R2: Rate code c (configuration bits [2:0]) gives an `sck` half period of 2^c clock cycles for c = 0..6. Code 7 behaves like code 6, which leaves seven distinct rates.
- R3: A write to index 0 loads all eight configuration bits. A write to index 1 replaces only bits [2:0] and keeps bits [7:3].
- R4: The message word holds the byte count in bits [3:0] and the type in bits [13:12]. A message of N bytes keeps the block busy for 2^c·(16N+1) cycles, and N = 0 gives one idle half period.
- R5: Type 2'b11 is full duplex. Transmit byte k goes out MSB first on `mosi`, and the byte received in the same slot lands in receive entry k.
- R6: Type 2'b10 is half-duplex read. `mosi` stays 0 and the received bytes are stored.
- R7: Type 2'b01 is half-duplex write. Bytes are sent, the receive buffer is left unchanged and the tail reads 0. Type 2'b00 clocks with `mosi` at 0 and stores nothing.
- R8: Configuration bit 4 sets the clock polarity and bit 5 the phase. `mosi` changes at the start of each even half period and `miso` is sampled at the end of it. `sck` idles at the polarity level.
- R9: A command starts only when bits [3:0] = 4'hA, the prepend count in bits [15:8] is zero, the device in bits [7:4] is below NDEV, the count is at most DEPTH and the block is idle. Any other command has no effect.
- R10: `csN[dev]` alone is low from the cycle after the command until one half period after the last bit. Busy (status bit 0) is 1 over the same span.
- R11: Completion sets interrupt status bit 0, and `irq` equals that bit ANDed with mask bit 0.
- R12: Writing 1 to status bit 0 (all-ones clears every bit) clears it. A completion in the same cycle as a clear leaves the bit set.
- R13: The receive tail reads the number of bytes stored by the last message.
- R14: A new command is accepted in the first cycle after busy falls, so full-buffer write messages can be chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register or buffer write strobe |
| regAddr | input | AW | Window address, AW = log2(DEPTH)+2 |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NDEV | Active-low chip selects |
| irq | output | 1 | Command-done interrupt |

## Verification
The edge that ends a message and a software write clearing the command-done bit can fall on the same clock. To force this, the bench writes the all-ones clear pattern on every cycle its model still calls busy, so the last such write lands on the completion edge. After that edge the status bit must read 1 and `irq` must stay high. A second overlap is a command written while a message is still running. Every cycle the chip selects and serial pins are compared with the model, to show that the command is ignored and the running transfer carries on untouched.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic sample;   // end of an even half period: capture miso
    logic byteEnd;  // sample that completes a byte
    logic finish;   // last half period of the message has elapsed
  } spimStrobe_t;

  localparam logic [2:0] REG_CFG   = 3'd0;
  localparam logic [2:0] REG_RATE  = 3'd1;
  localparam logic [2:0] REG_MSG   = 3'd2;
  localparam logic [2:0] REG_CMD   = 3'd3;
  localparam logic [2:0] REG_ISTAT = 3'd4;
  localparam logic [2:0] REG_IMASK = 3'd5;
  localparam logic [2:0] REG_TAIL  = 3'd6;
  localparam logic [2:0] REG_STAT  = 3'd7;

  localparam logic [3:0] OP_START = 4'hA;
  localparam int MAX_RATE = 6;           // slowest rate code
  localparam int HALF_W   = MAX_RATE;    // holds half period minus one
endpackage

// File: rtl/spim_ctl.sv
module spim_ctl
  import spim_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(16 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [CW-1:0]     goCount,
  input  logic [HALF_W-1:0] goHalfMax,
  output logic              busy,
  output logic [PW-1:0]     ph,
  output logic              shifting,
  output spimStrobe_t       strobe
);
  logic [HALF_W-1:0] halfCnt, halfMaxL;
  logic [PW-1:0]     lastPh;
  logic              tick;

  assign tick     = (halfCnt == '0);
  assign shifting = busy && (ph != lastPh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      ph       <= '0;
      halfCnt  <= '0;
      halfMaxL <= '0;
      lastPh   <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      ph       <= '0;
      halfCnt  <= goHalfMax;
      halfMaxL <= goHalfMax;
      lastPh   <= PW'({goCount, 4'b0000});
    end else if (busy) begin
      if (tick) begin
        halfCnt <= halfMaxL;
        if (ph == lastPh) busy <= 1'b0;
        else              ph   <= ph + 1'b1;
      end else begin
        halfCnt <= halfCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.sample  = busy && tick && shifting && !ph[0];
    strobe.byteEnd = strobe.sample && (ph[3:1] == 3'b111);
    strobe.finish  = busy && tick && (ph == lastPh);
  end
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NDEV  = 4,
  localparam int IW  = $clog2(DEPTH),
  localparam int AW  = IW + 2,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int PW  = $clog2(16 * DEPTH + 1),
  localparam int DVW = $clog2(NDEV)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [AW-1:0]     regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              miso,
  input  logic              busy,
  input  logic [PW-1:0]     ph,
  input  logic              shifting,
  input  spimStrobe_t       strobe,
  output logic              go,
  output logic [CW-1:0]     goCount,
  output logic [HALF_W-1:0] goHalfMax,
  output logic              sck,
  output logic              mosi,
  output logic [NDEV-1:0]   csN,
  output logic              irq
);
  logic [1:0]     region;
  logic [IW-1:0]  idx;
  logic [2:0]     regIdx;
  logic           ctlWr, bufWr;

  logic [7:0]     cfg;
  logic [CW-1:0]  msgCount;
  logic [1:0]     msgType;
  logic           iStat, iMask;
  logic [CW-1:0]  rxTail;
  logic [7:0]     txBuf [DEPTH];
  logic [7:0]     rxBuf [DEPTH];
  logic [6:0]     shIn;

  logic           txEnL, rxEnL, cpolL, cphaL;
  logic [DVW-1:0] devL;
  logic [2:0]     rateSh;
  logic [IW-1:0]  byteIdx;
  logic [2:0]     bitIdx;

  assign region = regAddr[AW-1:AW-2];
  assign idx    = regAddr[IW-1:0];
  assign regIdx = regAddr[2:0];
  assign ctlWr  = regWr && (region == 2'd0);
  assign bufWr  = regWr && (region == 2'd1);

  // command acceptance
  assign go = ctlWr && (regIdx == REG_CMD) && !busy
           && (regWdata[3:0] == OP_START)
           && (regWdata[15:8] == 8'd0)
           && (int'(regWdata[7:4]) < NDEV)
           && (int'(msgCount) <= DEPTH);

  assign goCount   = msgCount;
  assign rateSh    = (cfg[2:0] > 3'(MAX_RATE)) ? 3'(MAX_RATE) : cfg[2:0];
  assign goHalfMax = HALF_W'((7'd1 << rateSh) - 7'd1);

  // configuration, message and interrupt registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      msgCount <= '0;
      msgType  <= '0;
      iMask    <= 1'b0;
      iStat    <= 1'b0;
    end else begin
      if (ctlWr) begin
        case (regIdx)
          REG_CFG:   cfg      <= regWdata[7:0];
          REG_RATE:  cfg[2:0] <= regWdata[2:0];
          REG_MSG: begin
            msgCount <= regWdata[CW-1:0];
            msgType  <= regWdata[13:12];
          end
          REG_IMASK: iMask <= regWdata[0];
          default: ;
        endcase
      end
      // completion outranks a clear in the same cycle
      if (strobe.finish)
        iStat <= 1'b1;
      else if (ctlWr && (regIdx == REG_ISTAT) && regWdata[0])
        iStat <= 1'b0;
    end
  end

  // per-message snapshot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnL <= 1'b0;
      rxEnL <= 1'b0;
      cpolL <= 1'b0;
      cphaL <= 1'b0;
      devL  <= '0;
    end else if (go) begin
      txEnL <= msgType[0];
      rxEnL <= msgType[1];
      cpolL <= cfg[4];
      cphaL <= cfg[5];
      devL  <= DVW'(regWdata[7:4]);
    end
  end

  // transmit buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) txBuf[i] <= '0;
    end else if (bufWr) begin
      txBuf[idx] <= regWdata[7:0];
    end
  end

  // receive shift and buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shIn   <= '0;
      rxTail <= '0;
      for (int i = 0; i < DEPTH; i++) rxBuf[i] <= '0;
    end else begin
      if (go) rxTail <= '0;
      if (strobe.sample) shIn <= {shIn[5:0], miso};
      if (strobe.byteEnd && rxEnL) begin
        rxBuf[byteIdx] <= {shIn, miso};
        rxTail         <= rxTail + 1'b1;
      end
    end
  end

  // serial pins
  assign byteIdx = IW'(ph >> 4);
  assign bitIdx  = ~ph[3:1];
  assign mosi    = shifting && txEnL && txBuf[byteIdx][bitIdx];

  always_comb begin
    if (shifting)  sck = cpolL ^ cphaL ^ ph[0];
    else if (busy) sck = cpolL;
    else           sck = cfg[4];
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_cs
    assign csN[g] = !(busy && (int'(devL) == g));
  end

  assign irq = iStat && iMask;

  // read mux
  always_comb begin
    regRdata = '0;
    case (region)
      2'd0: begin
        case (regIdx)
          REG_CFG, REG_RATE: regRdata = {8'd0, cfg};
          REG_MSG:   regRdata = 16'(msgCount) | (16'(msgType) << 12);
          REG_ISTAT: regRdata = 16'(iStat);
          REG_IMASK: regRdata = 16'(iMask);
          REG_TAIL:  regRdata = 16'(rxTail);
          REG_STAT:  regRdata = 16'(busy);
          default:   regRdata = '0;
        endcase
      end
      2'd1:    regRdata = {8'd0, txBuf[idx]};
      2'd2:    regRdata = {8'd0, rxBuf[idx]};
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NDEV  = 4,
  localparam int AW = $clog2(DEPTH) + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWr,
  input  logic [AW-1:0]   regAddr,
  input  logic [15:0]     regWdata,
  output logic [15:0]     regRdata,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic [NDEV-1:0] csN,
  output logic            irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(16 * DEPTH + 1);

  logic              busy, shifting, go;
  logic [PW-1:0]     ph;
  logic [CW-1:0]     goCount;
  logic [HALF_W-1:0] goHalfMax;
  spimStrobe_t       strobe;

  spim_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .go(go), .goCount(goCount), .goHalfMax(goHalfMax),
    .busy(busy), .ph(ph), .shifting(shifting), .strobe(strobe)
  );

  spim_dp #(.DEPTH(DEPTH), .NDEV(NDEV)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .miso(miso), .busy(busy), .ph(ph), .shifting(shifting),
    .strobe(strobe), .go(go), .goCount(goCount), .goHalfMax(goHalfMax),
    .sck(sck), .mosi(mosi), .csN(csN), .irq(irq)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NDEV = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            go,
  input logic            busy,
  input logic            finish,
  input logic            iStat,
  input logic [NDEV-1:0] csN
);
  // R9: an accepted command raises busy and drives one select
  p_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    go |=> (busy && (csN != '1)));

  // R9 / R10: during a running message the selects do not move
  p_hold_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !finish) |=> $stable(csN));

  // R10: the message ends on the cycle after the finish strobe
  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> (!busy && (csN == '1)));

  // R11: status only rises after a completion
  p_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(iStat) |-> $past(finish));

  // R12: completion wins over a clear in the same cycle
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> iStat);
endmodule

bind spim_top spim_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rstN(rstN), .go(go), .busy(busy), .finish(strobe.finish),
  .iStat(u_dp.iStat), .csN(csN)
);

// File: tb/spim_top_bench.sv
module spim_top_bench;
  localparam int DEPTH = 8;
  localparam int NDEV  = 4;
  localparam int AW    = $clog2(DEPTH) + 2;
  localparam int RBASE = 0;
  localparam int TBASE = 1 << (AW - 2);
  localparam int XBASE = 2 << (AW - 2);

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, miso = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [15:0]   regWdata = '0;
  wire  [15:0]   regRdata;
  wire           sck, mosi, irq;
  wire  [NDEV-1:0] csN;

  always #10 clk = ~clk;

  spim_top #(.DEPTH(DEPTH), .NDEV(NDEV)) u_spim_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN), .irq(irq)
  );

  int nChk = 0, nFail = 0;
  bit monOn = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mCfg, mTx [DEPTH], mRx [DEPTH];
  int mCount, mType, mTail, mH, mN, mT, mDev, mSeed;
  bit mSt, mMask, mBusy, mTxEn, mRxEn, mCpol, mCpha;

  function automatic logic [7:0] slv(input int b);
    return 8'(b * 29 + mSeed);
  endfunction

  always @(posedge clk) begin
    bit busyPre, doneNow;
    int rg, ix, sh;
    if (!rstN) begin
      mCfg = 0; mCount = 0; mType = 0; mTail = 0; mSt = 0; mMask = 0;
      mBusy = 0; mT = 0; mH = 1; mN = 0; mDev = 0;
      for (int i = 0; i < DEPTH; i++) begin mTx[i] = 0; mRx[i] = 0; end
    end else begin
      busyPre = mBusy;
      doneNow = 0;
      if (mBusy) begin
        mT++;
        if (mT == mH * (16 * mN + 1)) begin
          mBusy = 0; doneNow = 1;
          mTail = mRxEn ? mN : 0;
          if (mRxEn) for (int b = 0; b < mN; b++) mRx[b] = slv(b);
        end
      end
      if (regWr) begin
        rg = int'(regAddr) / TBASE;
        ix = int'(regAddr) % TBASE;
        if (rg == 1) mTx[ix] = regWdata[7:0];
        else if (rg == 0) begin
          case (ix % 8)
            0: mCfg = regWdata[7:0];
            1: mCfg[2:0] = regWdata[2:0];
            2: begin mCount = regWdata[3:0]; mType = regWdata[13:12]; end
            3: if (!busyPre && regWdata[3:0] == 4'hA && regWdata[15:8] == 0
                   && regWdata[7:4] < NDEV && mCount <= DEPTH) begin
                 mBusy = 1; mT = 0; mN = mCount; mDev = regWdata[7:4];
                 mTxEn = mType[0]; mRxEn = mType[1];
                 mCpol = mCfg[4]; mCpha = mCfg[5];
                 sh = (mCfg[2:0] > 6) ? 6 : mCfg[2:0];
                 mH = 1 << sh;
               end
            4: if (regWdata[0]) mSt = 0;
            5: mMask = regWdata[0];
            default: ;
          endcase
        end
      end
      if (doneNow) mSt = 1;
    end
  end

  // per-cycle pin comparison and slave drive
  always @(negedge clk) begin
    int p;
    logic [NDEV-1:0] eCs;
    logic eSck, eMosi;
    if (rstN) begin
      p = mT / mH;
      eCs = mBusy ? ~(NDEV'(1) << mDev) : '1;
      if (mBusy && p < 16 * mN) begin
        eSck  = mCpol ^ mCpha ^ (p % 2 == 1);
        eMosi = mTxEn ? mTx[p / 16][7 - ((p / 2) % 8)] : 1'b0;
        miso  = slv(p / 16) >> (7 - ((p / 2) % 8));
      end else begin
        eSck  = mBusy ? mCpol : mCfg[4];
        eMosi = 1'b0;
        miso  = 1'b0;
      end
      if (monOn) begin
        check("R10 csN per cycle", 32'(csN), 32'(eCs));
        check("R8 sck per cycle", 32'(sck), 32'(eSck));
        check("R5 mosi per cycle", 32'(mosi), 32'(eMosi));
        check("R11 irq per cycle", 32'(irq), 32'(mSt & mMask));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = AW'(a); regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = AW'(RBASE + 7);
  endtask

  task automatic rd(input string tag, input int a, input logic [15:0] exp);
    regAddr = AW'(a);
    #1;
    check(tag, 32'(regRdata), 32'(exp));
    regAddr = AW'(RBASE + 7);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (mBusy && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic cmd(input int dev, input int prep, input int op);
    wr(RBASE + 3, 16'((prep << 8) | (dev << 4) | op));
  endtask

  task automatic runMsg(input string tag, input int n, input int typ, input int dev, input int seed);
    mSeed = seed;
    wr(RBASE + 2, 16'((typ << 12) | n));
    cmd(dev, 0, 4'hA);
    rd({tag, " busy after command"}, RBASE + 7, 16'(1));
    waitIdle();
    rd({tag, " idle"}, RBASE + 7, 16'(0));
    rd({tag, " R13 tail"}, RBASE + 6, 16'(mTail));
    for (int b = 0; b < DEPTH; b++) rd({tag, " rx byte"}, XBASE + b, 16'(mRx[b]));
    rd({tag, " R11 status"}, RBASE + 4, 16'(1));
    wr(RBASE + 4, 16'hFFFF);
    rd({tag, " R12 cleared"}, RBASE + 4, 16'(0));
  endtask

  // ---------------- sequence ----------------
  initial begin
    regAddr = AW'(RBASE + 7);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 csN reset", 32'(csN), 32'({NDEV{1'b1}}));
    check("R1 sck reset", 32'(sck), 0);
    check("R1 mosi reset", 32'(mosi), 0);
    check("R1 irq reset", 32'(irq), 0);
    rd("R1 cfg reset", RBASE + 0, 0);
    rd("R1 status reset", RBASE + 4, 0);
    rd("R1 tail reset", RBASE + 6, 0);
    rd("R1 busy reset", RBASE + 7, 0);
    monOn = 1'b1;

    for (int i = 0; i < DEPTH; i++) wr(TBASE + i, 16'(8'hA1 + 8'(i * 19)));
    wr(RBASE + 5, 16'(1));

    // R3 rate-only write keeps upper bits
    wr(RBASE + 0, 16'h00C8);
    wr(RBASE + 1, 16'hFFF9);
    rd("R3 rate write keeps bits 7:3", RBASE + 0, 16'h00C9);
    wr(RBASE + 0, 16'h0001);
    rd("R3 full write", RBASE + 0, 16'h0001);

    // R5 full duplex, mode 0, rate 1
    runMsg("R5 full duplex", 3, 3, 2, 5);
    // R8 the other three modes at rate 0
    wr(RBASE + 0, 16'h0010); runMsg("R8 mode cpol", 2, 3, 1, 7);
    wr(RBASE + 0, 16'h0020); runMsg("R8 mode cpha", 2, 3, 0, 9);
    wr(RBASE + 0, 16'h0030); runMsg("R8 mode both", 2, 3, 3, 11);
    // R6 half read
    wr(RBASE + 0, 16'h0002); runMsg("R6 half read", 4, 2, 1, 40);
    // R7 half write: rx untouched, tail 0
    runMsg("R7 half write", 2, 1, 0, 77);
    // R7 clock-only type
    runMsg("R7 clocks only", 1, 0, 2, 3);
    // R4 zero-length message
    runMsg("R4 zero count", 0, 3, 1, 1);
    // R2 code 7 behaves as slowest rate
    wr(RBASE + 1, 16'h0007); runMsg("R2 code 7", 1, 3, 0, 21);
    wr(RBASE + 1, 16'h0000);

    // R9 rejected commands
    wr(RBASE + 2, 16'h3002);
    cmd(0, 1, 4'hA);  rd("R9 prepend nonzero ignored", RBASE + 7, 0);
    cmd(0, 0, 4'h5);  rd("R9 bad opcode ignored", RBASE + 7, 0);
    cmd(5, 0, 4'hA);  rd("R9 device out of range ignored", RBASE + 7, 0);
    wr(RBASE + 2, 16'h3009);
    cmd(0, 0, 4'hA);  rd("R9 count above depth ignored", RBASE + 7, 0);
    // R9 command while busy ignored (per-cycle csN check covers it)
    mSeed = 60;
    wr(RBASE + 2, 16'h3002);
    cmd(0, 0, 4'hA);
    cmd(3, 0, 4'hA);
    check("R9 busy command ignored csN", 32'(csN), 32'(4'b1110));
    waitIdle();
    wr(RBASE + 4, 16'hFFFF);

    // R12 clear colliding with completion
    mSeed = 90;
    wr(RBASE + 2, 16'h3001);
    cmd(2, 0, 4'hA);
    while (mBusy) begin
      regWr = 1'b1; regAddr = AW'(RBASE + 4); regWdata = 16'hFFFF;
      @(negedge clk);
    end
    regWr = 1'b0; regAddr = AW'(RBASE + 7);
    rd("R12 completion wins over clear", RBASE + 4, 16'(1));
    check("R12 irq held", 32'(irq), 1);
    wr(RBASE + 4, 16'h0001);

    // R14 chained full-buffer writes
    mSeed = 5;
    wr(RBASE + 2, 16'h1008);
    cmd(1, 0, 4'hA);
    waitIdle();
    for (int i = 0; i < DEPTH; i++) wr(TBASE + i, 16'(8'h3C ^ 8'(i * 7)));
    cmd(1, 0, 4'hA);
    rd("R14 chained command accepted", RBASE + 7, 16'(1));
    waitIdle();
    rd("R14 chain done tail", RBASE + 6, 0);

    repeat (4) @(negedge clk);
    monOn = 1'b0;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule